// File: doc/BRIEF.md
# Serial SAR ADC Control Sequencer

This block is the digital controller for a four-input successive-approximation converter with a clocked serial port. While the active-low select is held low, the host clocks in an 8-bit command word, MSB first. The sequencer decodes the command into an input-multiplexer setting. The setting is either one input against the common return, or a pseudo-differential pair taken from inputs 0/1 or inputs 2/3. The sequencer opens and closes the track/hold window at fixed bit positions of the command.

After the hold instant, the sampling node is switched to the negative input. The block then runs a 10-step binary search. On each step it drives a trial code to the capacitive DAC and reads back a single comparator bit. When the search ends it raises a one-SCLK completion strobe and returns the sampling node to the positive input. It then shifts the result out MSB first on falling SCLK edges.

SCLK, select and data are sampled with a faster system clock through a synchroniser, so every action happens on a detected SCLK edge. Raising select at any time abandons the sequence. The serial output is then released through its pad enable.

Top module: `sar_seq_top`

## Requirements
- R1: While idle, rising SCLK edges with serial input 0 are ignored; the command begins at the first rising edge that samples a 1 (the start bit), and all command bits are sampled on rising SCLK, MSB first.
- R2: Command layout, MSB first: bit 7 start (1), bits 6..4 input select, bit 3 mode (1 = single-ended, 0 = differential), bits 2..0 ignored; select bit 6 is ignored, so only bits 5..4 choose the input.
- R3: In single-ended mode, on the falling edge after the fifth command bit, `mux_pos` equals select bits 5..4, `mux_neg_com` is 1 and `mux_neg` is 00.
- R4: In differential mode, `mux_pos` equals select bits 5..4, `mux_neg` is the other member of the same pair ({bit 5, not bit 4}) and `mux_neg_com` is 0.
- R5: `th_track` is 0 after the falling edges that follow command bits 1 to 4, and goes to 1 on the falling edge after the fifth bit; it changes only on falling SCLK edges.
- R6: On the falling edge after the eighth command bit, `th_track` goes to 0, `mux_neg_phase` goes to 1 and `dac_code` becomes the mid-scale trial 10'h200; `mux_neg_phase` and `th_track` are never 1 together.
- R7: During conversion each rising SCLK samples `cmp_in`. A 1 keeps the trial bit and a 0 clears it. The next trial (the decided upper bits plus the next lower bit set) appears on the following falling edge. After the tenth decision, `dac_code` equals the final result. `dac_code` changes only on falling SCLK edges or on abort.
- R8: On the falling edge after the tenth conversion clock, `sstrb` goes to 1, `th_track` to 1 and `mux_neg_phase` to 0; `sstrb` returns to 0 on the next falling edge.
- R9: The ten falling edges after the strobe edge present result bits 9 down to 0 on `dout`; the falling edge after that drives `dout` to 0 and returns the block to idle.
- R10: Select high aborts at any point: `th_track`, `mux_neg_phase`, `sstrb` and `dout_oe` go to 0, and the next command after select returns low is decoded from its own start bit.
- R11: `dout_oe` is 1 whenever select is low, and `dout` is 0 outside the result bits.
- R12: After a completed conversion, `th_track` stays 1 through idle clocks until the falling edge after the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high aborts and releases the output |
| din | input | 1 | Serial command input |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Pad enable for `dout` (0 = high impedance) |
| sstrb | output | 1 | Conversion-complete strobe |
| th_track | output | 1 | Track/hold control, 1 = track |
| mux_neg_phase | output | 1 | Sampling node switched to the negative input |
| mux_pos | output | 2 | Positive input select |
| mux_neg | output | 2 | Negative input select in differential mode |
| mux_neg_com | output | 1 | Negative input is the common return |
| dac_code | output | RES_BITS | Trial code to the capacitive DAC |

## Verification
A miscounted bit counter shows up within one SCLK period as a track edge, hold edge or strobe that lands one falling edge early or late. The bench checks these outputs after every falling edge. A wrong decode of the command is visible at the mux outputs on the falling edge after the fifth bit. A wrong SAR decision corrupts `dac_code` on the very next falling edge, long before the serial result is read. Stale state after an abort is exposed by the next full command, whose track window and result must be exact.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   // sequencer phase
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CTRL = 2'd1,
      PH_CONV = 2'd2,
      PH_OUT  = 2'd3
   } seq_phase_t;

   // start(1) + select(3) + mode(1): track opens once the mode bit is in
   localparam int FIELD_END = 5;
   // retained bits: select[1:0] and mode
   localparam int FIELD_W   = 3;

   typedef struct packed {
      logic [1:0] pos;
      logic [1:0] neg;
      logic       neg_com;
   } mux_sel_t;

   localparam mux_sel_t MUX_RESET = '{pos: 2'b00, neg: 2'b00, neg_com: 1'b1};

   function automatic mux_sel_t decode_mux(input logic [1:0] sel, input logic single);
      mux_sel_t m;
      m.pos     = sel;
      m.neg     = single ? 2'b00 : {sel[1], ~sel[0]};
      m.neg_com = single;
      return m;
   endfunction

endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
   parameter int                 WIDTH   = 3,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else if (s == 0) stg[s] <= d;
               else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     shift_en,
   input  logic     bit_in,
   input  logic     latch,
   output mux_sel_t mux_o
);

   logic [FIELD_W-1:0] fld_q;

   // only the last FIELD_W bits before the latch point are kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fld_q <= '0;
      else if (shift_en) fld_q <= {fld_q[FIELD_W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mux_o <= MUX_RESET;
      else if (latch) mux_o <= decode_mux(fld_q[2:1], fld_q[0]);
   end

endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
   parameter int RES_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                arm,
   input  logic                decide,
   input  logic                advance,
   input  logic                finalize,
   input  logic                cmp,
   output logic [RES_BITS-1:0] dac_code,
   output logic [RES_BITS-1:0] result
);

   localparam int IW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
   localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};

   logic [IW-1:0]       idx_q;
   logic [IW-1:0]       nidx;
   logic [RES_BITS-1:0] next_bit;

   assign nidx = idx_q - IW'(1);

   always_comb begin
      for (int i = 0; i < RES_BITS; i++) next_bit[i] = (nidx == IW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         dac_code <= '0;
         idx_q    <= '0;
      end else if (clr) begin
         result   <= '0;
         dac_code <= '0;
         idx_q    <= '0;
      end else begin
         if (arm) begin
            result   <= '0;
            idx_q    <= IW'(RES_BITS-1);
            dac_code <= MID;
         end
         if (decide)   result[idx_q] <= cmp;
         if (advance) begin
            idx_q    <= nidx;
            dac_code <= result | next_bit;
         end
         if (finalize) dac_code <= result;
      end
   end

endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out #(
   parameter int RES_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load,
   input  logic                step,
   input  logic [RES_BITS-1:0] result,
   output logic                dout_q,
   output logic                strobe,
   output logic                empty
);

   localparam int OW = $clog2(RES_BITS+1);

   logic [RES_BITS-1:0] sh_q;
   logic [OW-1:0]       ocnt_q;

   assign empty = (ocnt_q == OW'(RES_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         ocnt_q <= OW'(RES_BITS);
         dout_q <= 1'b0;
         strobe <= 1'b0;
      end else if (clr) begin
         sh_q   <= '0;
         ocnt_q <= OW'(RES_BITS);
         dout_q <= 1'b0;
         strobe <= 1'b0;
      end else if (load) begin
         sh_q   <= result;
         ocnt_q <= '0;
         strobe <= 1'b1;
      end else if (step) begin
         strobe <= 1'b0;
         if (!empty) begin
            dout_q <= sh_q[RES_BITS-1];
            sh_q   <= {sh_q[RES_BITS-2:0], 1'b0};
            ocnt_q <= ocnt_q + OW'(1);
         end else begin
            dout_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
   import sar_seq_pkg::*;
#(
   parameter int RES_BITS    = 10,
   parameter int CTRL_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                din,
   input  logic                cmp_in,
   output logic                dout,
   output logic                dout_oe,
   output logic                sstrb,
   output logic                th_track,
   output logic                mux_neg_phase,
   output logic [1:0]          mux_pos,
   output logic [1:0]          mux_neg,
   output logic                mux_neg_com,
   output logic [RES_BITS-1:0] dac_code
);

   localparam int CMAX = (CTRL_BITS > RES_BITS) ? CTRL_BITS : RES_BITS;
   localparam int CW   = $clog2(CMAX + 1);

   generate
      if (RES_BITS < 2)              begin : g_bad_res  $error("RES_BITS must be at least 2");             end
      if (CTRL_BITS <= FIELD_END)    begin : g_bad_ctrl $error("CTRL_BITS must exceed the decoded field"); end
      if (SYNC_STAGES > 4)           begin : g_bad_sync $error("SYNC_STAGES above 4 is not supported");   end
   endgenerate

   // ---------------- input synchronisation and edge detection
   logic [2:0] raw_in, syn_in;
   logic       s_sclk, cs_hi, s_din, sclk_d;
   logic       sclk_rise, sclk_fall;

   assign raw_in = {sclk, cs_n, din};

   sar_seq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   assign s_sclk = syn_in[2];
   assign cs_hi  = syn_in[1];
   assign s_din  = syn_in[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= s_sclk;
   end

   assign sclk_rise = s_sclk & ~sclk_d & ~cs_hi;
   assign sclk_fall = ~s_sclk & sclk_d & ~cs_hi;

   // ---------------- sequencer
   seq_phase_t phase_q;
   logic [CW-1:0] cnt_q;
   logic          shift_p, latch_p, arm_p, decide_p, advance_p, done_p, step_p;
   logic          out_empty;
   logic [RES_BITS-1:0] sar_result;
   mux_sel_t      mux_q;

   assign shift_p   = sclk_rise & (phase_q == PH_CTRL) & (cnt_q <  CW'(FIELD_END));
   assign latch_p   = sclk_fall & (phase_q == PH_CTRL) & (cnt_q == CW'(FIELD_END));
   assign arm_p     = sclk_fall & (phase_q == PH_CONV) & (cnt_q == '0);
   assign decide_p  = sclk_rise & (phase_q == PH_CONV) & (cnt_q != CW'(RES_BITS));
   assign advance_p = sclk_fall & (phase_q == PH_CONV) & (cnt_q != '0) & (cnt_q != CW'(RES_BITS));
   assign done_p    = sclk_fall & (phase_q == PH_CONV) & (cnt_q == CW'(RES_BITS));
   assign step_p    = sclk_fall & (phase_q == PH_OUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (cs_hi) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (sclk_rise) begin
         case (phase_q)
            PH_IDLE: if (s_din) begin
               phase_q <= PH_CTRL;
               cnt_q   <= CW'(1);
            end
            PH_CTRL: if (cnt_q == CW'(CTRL_BITS-1)) begin
               phase_q <= PH_CONV;
               cnt_q   <= '0;
            end else begin
               cnt_q   <= cnt_q + CW'(1);
            end
            PH_CONV: if (cnt_q != CW'(RES_BITS)) cnt_q <= cnt_q + CW'(1);
            default: ;
         endcase
      end else if (done_p) begin
         phase_q <= PH_OUT;
      end else if (step_p && out_empty) begin
         phase_q <= PH_IDLE;
      end
   end

   // track/hold and sampling-node control, all on falling SCLK
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         th_track      <= 1'b0;
         mux_neg_phase <= 1'b0;
      end else if (cs_hi) begin
         th_track      <= 1'b0;
         mux_neg_phase <= 1'b0;
      end else if (sclk_fall) begin
         if (phase_q == PH_CTRL && cnt_q < CW'(FIELD_END)) th_track <= 1'b0;
         if (latch_p) th_track <= 1'b1;
         if (arm_p) begin
            th_track      <= 1'b0;
            mux_neg_phase <= 1'b1;
         end
         if (done_p) begin
            th_track      <= 1'b1;
            mux_neg_phase <= 1'b0;
         end
      end
   end

   sar_seq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_p),
      .bit_in   (s_din),
      .latch    (latch_p),
      .mux_o    (mux_q)
   );

   sar_seq_sar #(.RES_BITS(RES_BITS)) u_sar (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cs_hi),
      .arm      (arm_p),
      .decide   (decide_p),
      .advance  (advance_p),
      .finalize (done_p),
      .cmp      (cmp_in),
      .dac_code (dac_code),
      .result   (sar_result)
   );

   sar_seq_out #(.RES_BITS(RES_BITS)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cs_hi),
      .load   (done_p),
      .step   (step_p),
      .result (sar_result),
      .dout_q (dout),
      .strobe (sstrb),
      .empty  (out_empty)
   );

   assign dout_oe     = ~cs_hi;
   assign mux_pos     = mux_q.pos;
   assign mux_neg     = mux_q.neg;
   assign mux_neg_com = mux_q.neg_com;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int RES_BITS = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_hi,
   input logic                sclk_fall,
   input logic                th_track,
   input logic                mux_neg_phase,
   input logic                sstrb,
   input logic                dout_oe,
   input logic [RES_BITS-1:0] dac_code
);

   AST_TRACK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(th_track) |-> $past(sclk_fall));                                   // R5

   AST_HOLD_EXCLUDES_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      mux_neg_phase |-> !th_track);                                            // R6

   AST_DAC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !cs_hi) |=> $stable(dac_code));                           // R7

   AST_STROBE_ONE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (sstrb && sclk_fall) |=> !sstrb);                                        // R8

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (!th_track && !sstrb && !mux_neg_phase));                      // R10

   AST_OE_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe == !cs_hi);                                                      // R11

endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cs_hi         (cs_hi),
   .sclk_fall     (sclk_fall),
   .th_track      (th_track),
   .mux_neg_phase (mux_neg_phase),
   .sstrb         (sstrb),
   .dout_oe       (dout_oe),
   .dac_code      (dac_code)
);

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;

   localparam int RES  = 10;
   localparam int HALF = 6;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, sclk, cs_n, din, cmp_in;
   logic dout, dout_oe, sstrb, th_track, mux_neg_phase, mux_neg_com;
   logic [1:0] mux_pos, mux_neg;
   logic [RES-1:0] dac_code;
   logic [RES-1:0] code_in;

   int n_chk  = 0;
   int n_fail = 0;
   logic exp_idle_track;

   // ideal comparator against the stored input code
   assign cmp_in = (dac_code <= code_in);

   sar_seq_top u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .cmp_in(cmp_in),
      .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb), .th_track(th_track),
      .mux_neg_phase(mux_neg_phase), .mux_pos(mux_pos), .mux_neg(mux_neg),
      .mux_neg_com(mux_neg_com), .dac_code(dac_code)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [RES-1:0] exp_trial(input logic [RES-1:0] code, input int k);
      logic [RES-1:0] m;
      m = {RES{1'b1}} << (RES - k);
      return (code & m) | (RES'(1) << (RES - 1 - k));
   endfunction

   // one SCLK period; returns after the falling edge has taken effect
   task automatic send_bit(input logic b);
      @(negedge clk) din = b;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic do_abort();
      @(negedge clk) cs_n = 1'b1;
      repeat (3*HALF) @(negedge clk);
      chk(dout_oe == 1'b0,       "R10 dout_oe released", 32'(dout_oe), 0);
      chk(th_track == 1'b0,      "R10 track cleared",    32'(th_track), 0);
      chk(sstrb == 1'b0,         "R10 strobe cleared",   32'(sstrb), 0);
      chk(mux_neg_phase == 1'b0, "R10 neg phase cleared", 32'(mux_neg_phase), 0);
      send_bit(1'b1);
      send_bit(1'b1);
      @(negedge clk) cs_n = 1'b0;
      repeat (3*HALF) @(negedge clk);
      chk(dout_oe == 1'b1 && dout == 1'b0, "R11 driven low after select", {dout_oe, dout}, 32'h2);
      exp_idle_track = 1'b0;
   endtask

   task automatic run_txn(input logic [RES-1:0] code, input logic [2:0] sel, input logic single,
                          input logic [2:0] pwr, input int lead, input int abort_at);
      logic [7:0] w;
      int step;
      step    = 0;
      code_in = code;
      w       = {1'b1, sel, single, pwr};
      for (int i = 0; i < lead; i++) send_bit(1'b0);
      if (lead > 0) begin
         chk(th_track == exp_idle_track, "R12 idle track kept", 32'(th_track), 32'(exp_idle_track));
         chk(mux_neg_phase == 1'b0, "R1 zeros start nothing", 32'(mux_neg_phase), 0);
      end
      for (int j = 1; j <= 8; j++) begin
         send_bit(w[8-j]);
         step++;
         if (j < 5) chk(th_track == 1'b0, "R5 no track before bit5", 32'(th_track), 0);
         if (j == 5) begin
            chk(th_track == 1'b1, "R5 track after bit5", 32'(th_track), 1);
            chk(mux_pos == sel[1:0], "R2 R3 R4 mux_pos", 32'(mux_pos), 32'(sel[1:0]));
            if (single) begin
               chk(mux_neg_com == 1'b1 && mux_neg == 2'b00, "R3 neg to common",
                   {mux_neg_com, mux_neg}, 32'h4);
            end else begin
               chk(mux_neg_com == 1'b0 && mux_neg == {sel[1], ~sel[0]}, "R4 neg pair member",
                   {mux_neg_com, mux_neg}, {1'b0, sel[1], ~sel[0]});
            end
         end
         if (j == 6 || j == 7) chk(th_track == 1'b1, "R5 track held", 32'(th_track), 1);
         if (j == 8) begin
            chk(th_track == 1'b0 && mux_neg_phase == 1'b1, "R6 hold and neg phase",
                {th_track, mux_neg_phase}, 32'h1);
            chk(dac_code == 10'h200, "R6 mid-scale trial", 32'(dac_code), 32'h200);
         end
         if (step == abort_at) begin do_abort(); return; end
      end
      for (int k = 1; k <= RES; k++) begin
         send_bit(1'b0);
         step++;
         if (k < RES) begin
            chk(dac_code == exp_trial(code, k), "R7 trial code", 32'(dac_code), 32'(exp_trial(code, k)));
            chk(sstrb == 1'b0, "R8 no early strobe", 32'(sstrb), 0);
         end else begin
            chk(dac_code == code, "R7 final code", 32'(dac_code), 32'(code));
            chk(sstrb && th_track && !mux_neg_phase, "R8 strobe and reconnect",
                {sstrb, th_track, mux_neg_phase}, 32'h6);
         end
         if (step == abort_at) begin do_abort(); return; end
      end
      for (int k = 1; k <= RES; k++) begin
         send_bit(1'b0);
         step++;
         chk(dout == code[RES-k], "R9 result bit", 32'(dout), 32'(code[RES-k]));
         if (k == 1) chk(sstrb == 1'b0, "R8 strobe one period", 32'(sstrb), 0);
         if (step == abort_at) begin do_abort(); return; end
      end
      send_bit(1'b0);
      step++;
      chk(dout == 1'b0 && dout_oe == 1'b1, "R9 R11 tail low", {dout_oe, dout}, 32'h2);
      exp_idle_track = 1'b1;
      if (step == abort_at) do_abort();
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] seed_v;
      seed_v = $urandom(32'h5A17);
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; din = 1'b0; code_in = '0;
      exp_idle_track = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3*HALF) @(negedge clk);
      chk(dout_oe == 1'b0 && sstrb == 1'b0, "R10 reset released", {dout_oe, sstrb}, 0);
      chk(th_track == 1'b0 && mux_neg_phase == 1'b0 && dac_code == '0, "R6 reset idle",
          {th_track, mux_neg_phase, 22'(dac_code)}, 0);
      @(negedge clk) cs_n = 1'b0;
      repeat (3*HALF) @(negedge clk);
      chk(dout_oe == 1'b1 && dout == 1'b0, "R11 enable on select", {dout_oe, dout}, 32'h2);

      // directed corner cases
      run_txn(10'h000, 3'b000, 1'b1, 3'b000, 0, 0);
      run_txn(10'h3FF, 3'b011, 1'b0, 3'b111, 3, 0);
      run_txn(10'h200, 3'b110, 1'b0, 3'b010, 1, 0);
      run_txn(10'h1FF, 3'b101, 1'b1, 3'b101, 2, 0);
      run_txn(10'h155, 3'b010, 1'b0, 3'b000, 0, 6);
      run_txn(10'h2AA, 3'b001, 1'b1, 3'b000, 2, 0);
      run_txn(10'h0F0, 3'b111, 1'b0, 3'b011, 0, 13);
      run_txn(10'h30C, 3'b100, 1'b1, 3'b000, 1, 22);
      run_txn(10'h001, 3'b000, 1'b0, 3'b000, 0, 0);

      // constrained random traffic
      for (int t = 0; t < 28; t++) begin
         logic [RES-1:0] c;
         int ab;
         c  = RES'($urandom);
         ab = ($urandom % 4 == 0) ? int'(1 + $urandom % 29) : 0;
         run_txn(c, 3'($urandom), 1'($urandom), 3'($urandom), int'($urandom % 4), ab);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule